// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

This block is a 64-bit watchdog that sits behind a 32-bit register port. Software selects the watchdog timer mode and releases both 32-bit halves in a global control register. It can then preload the 64-bit counter and the 64-bit period, which are each split into a low and a high word. The unit is armed by writing two fixed keys in turn to the watchdog control register, each write carrying the enable bit. Once armed, the watchdog cannot be turned off by software. Only the system reset input returns it to the disabled state.

While active, the counter advances by one every clock. The reset request output goes high when the counter reaches the period, or straight after any write of a key other than the two recognised ones. Software keeps the unit alive by writing the first key and then the second key. That pair zeroes the counter and leaves the unit active. The reset request is registered and stays high until the system reset input is applied. Pulse shaping of the reset and clock selection are done elsewhere.

Top module: `wdk_top`

## Requirements
- R1: After reset, rst_req is 0 and every readable register reads 0: counter low and high words, period low and high words, global control, and watchdog control.
- R2: Writes to the watchdog control register are ignored unless both of these hold in the global control register at 0x24: bits 3:2 equal 2, and bits 1:0 equal 2'b11. When they are ignored, the enable bit (bit 14 at 0x28) still reads 0.
- R3: The watchdog control register is at 0x28, with the key in bits 31:16 and the enable bit at bit 14. In the disabled state, writing key 0xA5C6 with bit 14 set moves the unit to pre-active. In pre-active, bit 14 reads 1 and the counter does not advance.
- R4: In pre-active, writing key 0xDA7E with bit 14 set makes the unit active. From then on the 64-bit counter increases by exactly 1 per clock.
- R5: While active, a watchdog control write whose key is neither 0xA5C6 nor 0xDA7E sets rst_req on the same clock edge. The value 0x00004000 is one such write. A wrong key written in pre-active is ignored and does not set rst_req.
- R6: Suppose the unit becomes active on edge k with the counter at 0 and the period at P. Then rst_req is still 0 after edge k+P and is 1 after edge k+P+1.
- R7: While active, writing 0xA5C6 and then 0xDA7E zeroes the counter on the edge of the second write. The unit stays active and rst_req is not set.
- R8: Once the enable bit reads 1, no write clears it. Writes to the global control, counter and period registers are then ignored.
- R9: Once set, rst_req stays 1, whatever is written, until rst_n is asserted.
- R10: The counter low and high words are at 0x10 and 0x14, and the period words are at 0x18 and 0x1C. Both are writable while the unit is disabled. A carry out of the counter's low word increments its high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | Registered, sticky chip reset request |

## Verification
A corrupted key state machine shows up at the ports in one of two ways. The enable bit reads back wrongly in the cycle after the write that should have moved it. Or rst_req rises, or fails to rise, on the edge of a key write. A counter fault shows in the counter words a few cycles after arming. It also shifts the rst_req rising edge away from edge k+P+1. A service pair that fails to clear the counter is caught at once by reading the counter, and again when the first period runs out.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned KEY_LSB = 16;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned EN_BIT  = 14;

  typedef enum logic [1:0] {
    WD_OFF = 2'd0,
    WD_PRE = 2'd1,
    WD_RUN = 2'd2,
    WD_SVC = 2'd3
  } wd_state_t;

  function automatic logic [KEY_W-1:0] key_of(input logic [31:0] w);
    return w[KEY_LSB +: KEY_W];
  endfunction

  function automatic logic en_of(input logic [31:0] w);
    return w[EN_BIT];
  endfunction

  function automatic logic [31:0] wctl_image(input logic armed);
    logic [31:0] v;
    v = '0;
    v[EN_BIT] = armed;
    return v;
  endfunction

  function automatic logic [63:0] cnt_step(input logic [63:0] c);
    return c + 64'd1;
  endfunction
endpackage

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
  import wdk_pkg::*;
#(
  parameter logic [15:0] KEY_ARM = 16'hA5C6,
  parameter logic [15:0] KEY_GO  = 16'hDA7E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        wd_mode,
  output logic        armed,
  output logic        active,
  output logic        svc_clear,
  output logic        key_fault
);
  wd_state_t state, state_nx;
  logic [15:0] key;
  logic        en, is_arm, is_go, take;

  always_comb begin
    key    = key_of(ctl_wdata);
    en     = en_of(ctl_wdata);
    is_arm = (key == KEY_ARM);
    is_go  = (key == KEY_GO);
    take   = ctl_wr && wd_mode;
  end

  always_comb begin
    state_nx  = state;
    svc_clear = 1'b0;
    key_fault = 1'b0;
    if (take) begin
      unique case (state)
        WD_OFF: if (en && is_arm) state_nx = WD_PRE;
        WD_PRE: if (en && is_go)  state_nx = WD_RUN;
        WD_RUN: begin
          if (is_arm)      state_nx = WD_SVC;
          else if (!is_go) key_fault = 1'b1;
        end
        WD_SVC: begin
          if (is_go) begin
            state_nx  = WD_RUN;
            svc_clear = 1'b1;
          end else if (!is_arm) begin
            key_fault = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WD_OFF;
    else        state <= state_nx;
  end

  assign armed  = (state != WD_OFF);
  assign active = (state == WD_RUN) || (state == WD_SVC);

  assert_no_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_OFF) |=> (state == WD_OFF || state == WD_PRE));
  assert_stay_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);
  assert_enable_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  assert_prearm_only_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_PRE && !(take && en && is_go)) |=> (state == WD_PRE));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
  import wdk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W/DATA_W-1:0]    cnt_wr,
  input  logic [CNT_W/DATA_W-1:0]    prd_wr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       locked,
  input  logic                       run,
  input  logic                       svc_clear,
  output logic [CNT_W-1:0]           cnt_q,
  output logic [CNT_W-1:0]           prd_q,
  output logic                       expired
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (svc_clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_step(cnt_q);
    end else if (!locked) begin
      for (int h = 0; h < HALVES; h++)
        if (cnt_wr[h]) cnt_q[h*DATA_W +: DATA_W] <= wdata;
    end
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_prd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   prd_q[g*DATA_W +: DATA_W] <= '0;
      else if (prd_wr[g] && !locked) prd_q[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  assign expired = run && (cnt_q == prd_q);

  assert_service_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_clear |=> (cnt_q == '0));
  assert_period_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(prd_q));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !svc_clear) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int unsigned   DATA_W   = 32,
  parameter int unsigned   CNT_W    = 64,
  parameter int unsigned   ADDR_W   = 8,
  parameter logic [7:0]    OFS_CNT  = 8'h10,
  parameter logic [7:0]    OFS_PRD  = 8'h18,
  parameter logic [7:0]    OFS_GCTL = 8'h24,
  parameter logic [7:0]    OFS_WCTL = 8'h28,
  parameter logic [15:0]   KEY_ARM  = 16'hA5C6,
  parameter logic [15:0]   KEY_GO   = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int unsigned HALVES = CNT_W / DATA_W;
  localparam int unsigned STRIDE = DATA_W / 8;

  logic [3:0]        gctl;
  logic              wd_mode, armed, active, svc_clear, key_fault, expired, run;
  logic              ctl_wr, gctl_wr;
  logic [HALVES-1:0] cnt_wr, prd_wr, cnt_sel, prd_sel;
  logic [CNT_W-1:0]  cnt_q, prd_q;

  assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_WCTL));
  assign gctl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_GCTL));

  for (genvar g = 0; g < HALVES; g++) begin : g_dec
    assign cnt_sel[g] = (bus_addr == ADDR_W'(OFS_CNT + g*STRIDE));
    assign prd_sel[g] = (bus_addr == ADDR_W'(OFS_PRD + g*STRIDE));
    assign cnt_wr[g]  = bus_wr && cnt_sel[g];
    assign prd_wr[g]  = bus_wr && prd_sel[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gctl <= '0;
    else if (gctl_wr && !armed) gctl <= bus_wdata[3:0];
  end

  assign wd_mode = (gctl[3:2] == 2'd2) && (gctl[1:0] == 2'b11);

  wdk_keyfsm #(.KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(bus_wdata),
    .wd_mode(wd_mode), .armed(armed), .active(active),
    .svc_clear(svc_clear), .key_fault(key_fault)
  );

  assign run = active && !rst_req;

  wdk_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .prd_wr(prd_wr),
    .wdata(bus_wdata), .locked(armed), .run(run), .svc_clear(svc_clear),
    .cnt_q(cnt_q), .prd_q(prd_q), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= rst_req | expired | key_fault;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_WCTL)) bus_rdata = wctl_image(armed);
    if (bus_addr == ADDR_W'(OFS_GCTL)) bus_rdata = DATA_W'(gctl);
    for (int h = 0; h < HALVES; h++) begin
      if (cnt_sel[h]) bus_rdata = cnt_q[h*DATA_W +: DATA_W];
      if (prd_sel[h]) bus_rdata = prd_q[h*DATA_W +: DATA_W];
    end
  end

  assert_fault_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_fault |=> rst_req);
  assert_timeout_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> rst_req);
  assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  assert_gctl_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(gctl));
endmodule

// File: tb/wdk_top_bench.sv
`timescale 1ns/1ps
module wdk_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18,
                         A_PHI = 8'h1C, A_GCTL = 8'h24, A_WCTL = 8'h28;
  localparam logic [31:0] W_ARM = 32'hA5C6_4000, W_GO = 32'hDA7E_4000;

  always #4 clk = ~clk;

  wdk_top u_wdk_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    bus_wr = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] plo, input logic [31:0] phi);
    wr(A_GCTL, 32'h0000_000B);
    wr(A_CLO, 32'h0); wr(A_CHI, 32'h0);
    wr(A_PLO, plo);   wr(A_PHI, phi);
    wr(A_WCTL, W_ARM);
    wr(A_WCTL, W_GO);
  endtask

  task automatic t_reset_R1();
    logic [31:0] v;
    do_reset();
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd(A_CLO, v);  chk("R1 cnt lo", v, 0);
    rd(A_CHI, v);  chk("R1 cnt hi", v, 0);
    rd(A_PLO, v);  chk("R1 prd lo", v, 0);
    rd(A_PHI, v);  chk("R1 prd hi", v, 0);
    rd(A_GCTL, v); chk("R1 gctl", v, 0);
    rd(A_WCTL, v); chk("R1 wctl", v, 0);
  endtask

  task automatic t_mode_gate_R2();
    logic [31:0] v;
    do_reset();
    wr(A_GCTL, 32'h7);
    wr(A_WCTL, W_ARM);
    rd(A_WCTL, v); chk("R2 wrong mode ignored", v, 0);
    wr(A_GCTL, 32'h9);
    wr(A_WCTL, W_ARM);
    rd(A_WCTL, v); chk("R2 half not released ignored", v, 0);
    wr(A_GCTL, 32'hB);
    wr(A_WCTL, W_ARM);
    rd(A_WCTL, v); chk("R2 watchdog mode accepts", v, 32'h0000_4000);
  endtask

  task automatic t_prearm_R3();
    logic [31:0] v;
    do_reset();
    wr(A_GCTL, 32'hB);
    wr(A_WCTL, 32'hA5C6_0000);
    rd(A_WCTL, v); chk("R3 key without enable ignored", v, 0);
    wr(A_WCTL, W_ARM);
    rd(A_WCTL, v); chk("R3 pre-active enable", v, 32'h0000_4000);
    wait_cyc(3);
    rd(A_CLO, v); chk("R3 counter idle in pre-active", v, 0);
    wr(A_WCTL, 32'h1234_4000);
    chk("R5 wrong key in pre-active no reset", {31'b0, rst_req}, 0);
  endtask

  task automatic t_count_R4();
    logic [31:0] v;
    do_reset();
    arm(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(A_CLO, v); chk("R4 counter at arming", v, 0);
    wait_cyc(5);
    rd(A_CLO, v); chk("R4 counter after 5", v, 5);
  endtask

  task automatic t_badkey_R5();
    logic [31:0] v;
    do_reset();
    arm(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R5 no reset before bad key", {31'b0, rst_req}, 0);
    wr(A_WCTL, 32'h0000_4000);
    chk("R5 bad key reset", {31'b0, rst_req}, 1);
    wait_cyc(10);
    chk("R9 reset held", {31'b0, rst_req}, 1);
    wr(A_WCTL, W_ARM); wr(A_WCTL, W_GO);
    chk("R9 reset held after keys", {31'b0, rst_req}, 1);
    do_reset();
    chk("R9 reset cleared by rst_n", {31'b0, rst_req}, 0);
    rd(A_WCTL, v); chk("R9 disabled after rst_n", v, 0);
  endtask

  task automatic t_timeout_R6();
    do_reset();
    arm(32'd20, 32'd0);
    wait_cyc(20);
    chk("R6 not yet expired at k+P", {31'b0, rst_req}, 0);
    wait_cyc(1);
    chk("R6 expired at k+P+1", {31'b0, rst_req}, 1);
  endtask

  task automatic t_service_R7();
    logic [31:0] v;
    do_reset();
    arm(32'd30, 32'd0);
    wait_cyc(10);
    wr(A_WCTL, W_ARM);
    wr(A_WCTL, W_GO);
    rd(A_CLO, v); chk("R7 counter cleared", v, 0);
    rd(A_WCTL, v); chk("R7 still enabled", v, 32'h0000_4000);
    wait_cyc(25);
    chk("R7 no reset after service", {31'b0, rst_req}, 0);
    rd(A_CLO, v); chk("R7 counting resumed", v, 25);
  endtask

  task automatic t_sticky_R8();
    logic [31:0] v;
    do_reset();
    arm(32'h0000_1000, 32'd0);
    wr(A_WCTL, 32'hA5C6_0000);
    wr(A_WCTL, 32'hDA7E_0000);
    rd(A_WCTL, v); chk("R8 enable not cleared", v, 32'h0000_4000);
    wr(A_GCTL, 32'h0);
    rd(A_GCTL, v); chk("R8 gctl locked", v, 32'hB);
    wr(A_PLO, 32'h5);
    rd(A_PLO, v); chk("R8 period locked", v, 32'h0000_1000);
    wr(A_CHI, 32'h77);
    rd(A_CHI, v); chk("R8 counter locked", v, 0);
    chk("R8 no reset", {31'b0, rst_req}, 0);
  endtask

  task automatic t_carry_R10();
    logic [31:0] v;
    do_reset();
    wr(A_GCTL, 32'hB);
    wr(A_PLO, 32'hFFFF_FFFF); wr(A_PHI, 32'hFFFF_FFFF);
    wr(A_CLO, 32'hFFFF_FFFE);
    rd(A_CLO, v); chk("R10 counter low write", v, 32'hFFFF_FFFE);
    rd(A_PHI, v); chk("R10 period high write", v, 32'hFFFF_FFFF);
    wr(A_WCTL, W_ARM);
    wr(A_WCTL, W_GO);
    wait_cyc(3);
    rd(A_CLO, v); chk("R10 low wrapped", v, 1);
    rd(A_CHI, v); chk("R10 carry into high", v, 1);
  endtask

  initial begin
    t_reset_R1();
    t_mode_gate_R2();
    t_prearm_R3();
    t_count_R4();
    t_badkey_R5();
    t_timeout_R6();
    t_service_R7();
    t_sticky_R8();
    t_carry_R10();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule